// File: doc/BRIEF.md
# Direct-Sequence Spreading Transmitter

This block produces a baseband direct-sequence spread chip stream from a test message that is built into the block. A pseudo-noise (PN) generator creates one chip on each enabled clock. It is a six-stage maximal-length shift register, so its code repeats every 63 chips. The current message bit is XORed with the current chip to give the spread output. The message is a constant 200-bit array. An address counter that wraps around reads it, so the message repeats with no end.

Each message bit lasts exactly one full PN period of 63 chips. The address moves on when the PN register returns to its seed. A strobe marks the first chip of every period, so a receiver or a testbench can line up bit boundaries without counting. All state moves only on cycles where the chip-enable input is high. This lets the chip rate be any integer fraction of the clock.

Top module: `dsss_spreader`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PN register loads 6'b111111 and the message address loads 0. After that edge, `pn_chip`=1, `period_start`=1 and `data_bit` shows message bit 0.
- R2: On each enabled step the PN register state s[5:0] shifts left by one. The new s[0] is s[5] XOR s[0]; these are the two feedback stages of the x^6+x+1 polynomial. `pn_chip` always shows s[5].
- R3: The PN register never holds all zeros. `period_start` recurs exactly every 63 enabled steps.
- R4: `spread_chip` equals `data_bit` XOR `pn_chip` at every cycle.
- R5: `period_start` is high exactly while the PN register holds 6'b111111.
- R6: The message address advances by one only on the enabled step that returns the PN register to 6'b111111. `data_bit` is constant for the whole 63-chip period.
- R7: After message entry 199 the address wraps to entry 0.
- R8: While `chip_en` is low, all outputs and all internal state hold their values.
- R9: Message bit i (0 to 199) is 1 when i mod 3 = 1 or i mod 11 = 0, and 0 otherwise.
- R10: A reset asserted in the middle of a run restarts both the PN code and the message from their first positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Chip-rate enable; when high, the state advances one chip |
| data_bit | output | 1 | Current message bit |
| pn_chip | output | 1 | Current PN chip |
| spread_chip | output | 1 | Spread output, the message bit XOR the PN chip |
| period_start | output | 1 | High on the first chip of each PN period |

## Verification
The bench first runs a continuous enable for two PN periods. This separates a wrong feedback tap or a wrong chip bit, which changes the chip order, from a wrong period length, which moves the strobe. It then runs an irregular enable pattern with long idle gaps, so any state that moves without the enable is caught. A full pass through the message and three periods beyond it compares each period's data bit with the message formula. This detects an address that steps at the wrong time, a wrap at the wrong entry, or wrong message contents. A reset in the middle of a period checks that the PN code and the message address both restart together.

// File: rtl/dsss_pkg.sv
// Package: shared constants and the message-content function for the
// spreading transmitter. Assumes the message is a fixed pattern computed
// at elaboration, not loaded at run time.
package dsss_pkg;

    localparam int MSG_LEN_DEF = 200;
    localparam int PN_W_DEF    = 6;

    // Message bit i: set when i mod 3 is 1 or i mod 11 is 0.
    function automatic logic msg_bit(input int idx);
        return ((idx % 3) == 1) || ((idx % 11) == 0);
    endfunction

endpackage

// File: rtl/dsss_pn_gen.sv
// Maximal-length PN generator. Shifts left on each enabled step. The
// feedback bit is the top stage XOR stage PN_TAP. Assumes SEED is nonzero,
// so the register can never reach the all-zero lock-up state.
module dsss_pn_gen #(
    parameter int              PN_W   = 6,
    parameter int              PN_TAP = 0,
    parameter logic [PN_W-1:0] SEED   = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [PN_W-1:0] state,
    output logic [PN_W-1:0] state_nxt
);

    // Next state: shift left and insert the feedback bit.
    always_comb begin
        state_nxt = {state[PN_W-2:0], state[PN_W-1] ^ state[PN_TAP]};
    end

    // State register: load the seed on reset, move only when stepped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (step) begin
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/dsss_msg_addr.sv
// Wrapping message address counter. Moves by one on each advance pulse
// and returns to 0 after entry DEPTH-1. Assumes DEPTH >= 2.
module dsss_msg_addr #(
    parameter int DEPTH = 200,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Address register: clear on reset, step and wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (adv) begin
            if (addr == LAST) begin
                addr <= '0;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsss_msg_rom.sv
// Constant one-bit-wide message store. Contents come from the package
// function at elaboration. The read is combinational. Assumes addr < DEPTH.
module dsss_msg_rom #(
    parameter int DEPTH = 200,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic          bit_out
);

    logic [DEPTH-1:0] contents;

    // One constant entry per message position.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign contents[g] = dsss_pkg::msg_bit(g);
    end

    // Read port: select the addressed entry.
    always_comb begin
        bit_out = contents[addr];
    end

endmodule

// File: rtl/dsss_spreader.sv
// Top level of the spreading transmitter. One message bit is spread over
// one full PN period. The address advances on the step that returns the
// PN register to its seed. Assumes chip_en paces the chip rate.
module dsss_spreader #(
    parameter int              MSG_LEN = dsss_pkg::MSG_LEN_DEF,
    parameter int              PN_W    = dsss_pkg::PN_W_DEF,
    parameter int              PN_TAP  = 0,
    parameter logic [PN_W-1:0] PN_SEED = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_en,
    output logic data_bit,
    output logic pn_chip,
    output logic spread_chip,
    output logic period_start
);

    localparam int AW = $clog2(MSG_LEN);

    logic [PN_W-1:0] pn_state;
    logic [PN_W-1:0] pn_nxt;
    logic [AW-1:0]   msg_addr;
    logic            period_end;

    dsss_pn_gen #(
        .PN_W   (PN_W),
        .PN_TAP (PN_TAP),
        .SEED   (PN_SEED)
    ) u_pn (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (chip_en),
        .state     (pn_state),
        .state_nxt (pn_nxt)
    );

    // Period boundary: this enabled step brings the register back to its seed.
    always_comb begin
        period_end = chip_en && (pn_nxt == PN_SEED);
    end

    dsss_msg_addr #(
        .DEPTH (MSG_LEN)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (period_end),
        .addr  (msg_addr)
    );

    dsss_msg_rom #(
        .DEPTH (MSG_LEN)
    ) u_rom (
        .addr    (msg_addr),
        .bit_out (data_bit)
    );

    // Output stage: chip tap, spreading XOR and period strobe.
    always_comb begin
        pn_chip      = pn_state[PN_W-1];
        spread_chip  = data_bit ^ pn_chip;
        period_start = (pn_state == PN_SEED);
    end

endmodule

// File: rtl/dsss_spreader_checker.sv
// Property checker for dsss_spreader, attached by bind. It watches the
// ports and the PN state register. Assumes the default seed of all ones.
module dsss_spreader_checker #(
    parameter int PN_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            chip_en,
    input logic            data_bit,
    input logic            pn_chip,
    input logic            period_start,
    input logic [PN_W-1:0] pn_state
);

    localparam int PERIOD = (1 << PN_W) - 1;
    localparam int CW     = $clog2(PERIOD + 1) + 1;

    logic [CW-1:0] since_start;

    // Counts enabled steps since the last period strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_start <= '0;
        end else if (chip_en) begin
            since_start <= period_start ? CW'(1) : since_start + 1'b1;
        end
    end

    AST_PN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en |=> pn_state[PN_W-1:1] == $past(pn_state[PN_W-2:0])); // R2

    AST_PN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pn_state != '0); // R3

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && since_start != '0) |-> since_start == CW'(PERIOD)); // R3

    AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        since_start <= CW'(PERIOD)); // R3

    AST_STROBE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> pn_chip); // R5

    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> $stable(data_bit)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> $stable(pn_state) && $stable(data_bit)); // R8

endmodule

bind dsss_spreader dsss_spreader_checker #(.PN_W(PN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_en      (chip_en),
    .data_bit     (data_bit),
    .pn_chip      (pn_chip),
    .period_start (period_start),
    .pn_state     (pn_state)
);

// File: tb/dsss_spreader_bench.sv
`timescale 1ns/1ps
module dsss_spreader_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_en = 1'b0;
    logic data_bit, pn_chip, spread_chip, period_start;

    int n_vec = 0;
    int n_err = 0;
    logic [5:0] m_pn = 6'h3F;
    int m_addr = 0;

    always #2.5 clk = ~clk;

    dsss_spreader u_dsss_spreader (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_en      (chip_en),
        .data_bit     (data_bit),
        .pn_chip      (pn_chip),
        .spread_chip  (spread_chip),
        .period_start (period_start)
    );

    function automatic logic exp_msg(input int i);
        return ((i % 3) == 1) || ((i % 11) == 0);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic ed, ec;
        ed = exp_msg(m_addr);
        ec = m_pn[5];
        chk({tag, " data_bit"}, int'(data_bit), int'(ed));
        chk({tag, " pn_chip"}, int'(pn_chip), int'(ec));
        chk({tag, " spread_chip R4"}, int'(spread_chip), int'(ed ^ ec));
        chk({tag, " period_start R5"}, int'(period_start), int'(m_pn == 6'h3F));
    endtask

    // Called at a falling edge: check, drive, update the model, wait.
    task automatic step(input logic c, input string tag);
        logic [5:0] nxt;
        check_outputs(tag);
        chip_en = c;
        if (c) begin
            nxt = {m_pn[4:0], m_pn[5] ^ m_pn[0]};
            if (nxt == 6'h3F) m_addr = (m_addr + 1) % 200;
            m_pn = nxt;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        chip_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        m_pn = 6'h3F;
        m_addr = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check_outputs("R1 reset");
    endtask

    task automatic t_first_periods();
        do_reset();
        for (int i = 0; i < 126; i++) step(1'b1, "R2 R9 chip sequence");
    endtask

    task automatic t_period_len();
        int cnt;
        do_reset();
        for (int p = 0; p < 2; p++) begin
            cnt = 0;
            step(1'b1, "R3 period");
            cnt++;
            while (!period_start && cnt < 200) begin
                step(1'b1, "R3 period");
                cnt++;
            end
            chk("R3 steps between strobes", cnt, 63);
        end
    endtask

    task automatic t_gating();
        do_reset();
        for (int i = 0; i < 150; i++) begin
            step((i % 5) == 2 || (i % 7) == 0, "R8 gated");
        end
        for (int i = 0; i < 12; i++) step(1'b0, "R8 idle hold");
    endtask

    task automatic t_wrap();
        int k;
        do_reset();
        k = 0;
        chk("R6 R9 first bit", int'(data_bit), int'(exp_msg(0)));
        for (int i = 0; i < 203 * 63; i++) begin
            step(1'b1, "R6 R7 run");
            if (period_start) begin
                k++;
                chk("R7 R9 bit at period start", int'(data_bit), int'(exp_msg(k % 200)));
            end
        end
        chk("R7 periods seen", k, 203);
    endtask

    task automatic t_midreset();
        do_reset();
        for (int i = 0; i < 63 * 3 + 17; i++) step(1'b1, "R10 pre-reset");
        do_reset();
        check_outputs("R10 after reset");
        for (int i = 0; i < 70; i++) step(1'b1, "R10 restart");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_first_periods();
        t_period_len();
        t_gating();
        t_wrap();
        t_midreset();
        finish_run();
    end

endmodule